// File: doc/BRIEF.md
# Memory Response Ordering Buffer

This block sits between the issue side of a memory pipeline and its writeback stage. Every request accepted at the issue port gets a sequence tag from a counter that rises by one per accepted request. The memory side later hands responses back carrying that tag. The block decides which finished response the writeback stage sees next. The consumer then retires that response with a one-cycle completion strobe.

A mode bit picks the delivery policy. In program-order mode an arriving response only marks its entry finished. The presented response is always the oldest outstanding request, and it is shown only once that request is finished. In arrival-order mode an arriving response frees its request slot and joins a load queue or a store queue. The older arrival across the two queues is presented first. Issue backpressure takes account of requests the caller has in flight but has not yet presented. Each response queue reports whether it can take another entry.

Top module: `mem_resp_order`

## Requirements
- R1: After reset the block is in program-order mode (`mode_cur`=0) with no outstanding requests. `iss_ready`, `ld_wr_rdy` and `st_wr_rdy` are 1, `out_valid` and `err_flag` are 0, and `iss_tag` is 0.
- R2: `iss_ready` is 1 exactly when the tracked request count plus `iss_pend` is below QDEPTH (8) and the slot at index `iss_tag` mod QDEPTH is free. An issue is accepted when `iss_valid` and `iss_ready` are both 1. Each accepted issue takes the tag shown on `iss_tag`, and `iss_tag` then advances by one modulo 2^TAG_W (16).
- R3: In program-order mode a matching response only marks its entry finished. `out_valid` is 1 only when the oldest outstanding request in issue order is finished, and `out_tag`/`out_store` then show that request's tag and its issued type (1 = store). A response seen at one clock edge is visible at the outputs after that edge.
- R4: In program-order mode, `out_done` while `out_valid` is 1 retires the presented entry and moves the presentation to the next request in issue order. Without `out_done` the presented response stays unchanged.
- R5: In arrival-order mode a matching response frees its request slot at once. It is queued by its issued type: a load goes to the load queue and a store to the store queue. The queued entry is presented from the next cycle. When both queues hold entries, the earlier arrival is presented. `out_done` pops the presented entry.
- R6: `ld_wr_rdy` and `st_wr_rdy` are each 1 while the matching response queue holds fewer than QDEPTH entries.
- R7: A response whose tag matches no outstanding unfinished request sets `err_flag`. So does an arrival-order response whose queue is full. Such a response changes nothing else, and `err_flag` stays 1 until reset.
- R8: A change of `mode_req` takes effect at the next edge only when there are no tracked requests, both queues are empty and no issue is accepted in that cycle. Otherwise `mode_cur` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 1 | Requested policy: 0 program order, 1 arrival order |
| mode_cur | output | 1 | Policy in force |
| iss_valid | input | 1 | Request offered for issue |
| iss_store | input | 1 | Offered request is a store (0 = load) |
| iss_pend | input | PEND_W | Requests the caller holds that are not yet offered |
| iss_ready | output | 1 | Issue may be accepted this cycle |
| iss_tag | output | TAG_W | Tag given to the request accepted this cycle |
| rsp_valid | input | 1 | Response returning from memory |
| rsp_tag | input | TAG_W | Tag of the returning response |
| ld_wr_rdy | output | 1 | Load response queue has room |
| st_wr_rdy | output | 1 | Store response queue has room |
| out_valid | output | 1 | A response is presented to writeback |
| out_tag | output | TAG_W | Tag of the presented response |
| out_store | output | 1 | Presented response is a store |
| out_done | input | 1 | Writeback retires the presented response |
| err_flag | output | 1 | Sticky flag for unmatched or unqueueable responses |

## Verification
Most internal faults reach the ports within a cycle or two. A wrong done bit, head pointer or slot valid bit makes `out_valid` rise early, stick low or show the wrong `out_tag` in the cycle after the affected response or completion. A broken occupancy count first appears as `iss_ready` wrong, in the cycle where the count plus `iss_pend` crosses QDEPTH. An arrival-stamp or queue-pointer fault only shows when both queues hold entries, or when one fills. So the bench runs arrival-order phases with completions held back, so that the two queues hold entries together and the load queue fills.

// File: rtl/mro_pkg.sv
package mro_pkg;
  typedef enum logic {
    MODE_INORD   = 1'b0,
    MODE_ARRIVAL = 1'b1
  } mro_mode_e;
endpackage

// File: rtl/mro_track.sv
module mro_track #(
  parameter int unsigned QDEPTH = 8,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arrival_mode,
  input  logic              iss_valid,
  input  logic              iss_store,
  input  logic [PEND_W-1:0] iss_pend,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_hit,
  output logic              rsp_hit_store,
  input  logic              rsp_take,
  output logic              head_ready,
  output logic [TAG_W-1:0]  head_tag,
  output logic              head_store,
  input  logic              head_pop,
  input  logic              head_sync,
  output logic              tbl_empty
);
  localparam int unsigned IDX_W = $clog2(QDEPTH);
  localparam int unsigned OCC_W = $clog2(QDEPTH + 1);

  logic [TAG_W-1:0]  tail_q, tail_n, head_q, head_n;
  logic [OCC_W-1:0]  occ_q, occ_n;
  logic [QDEPTH-1:0] vld_q, vld_n, done_q, done_n, st_q, st_n;
  logic [TAG_W-1:0]  tag_q [QDEPTH];
  logic [TAG_W-1:0]  tag_n [QDEPTH];
  logic [IDX_W-1:0]  tidx, hidx, ridx;
  logic              iss_fire, free_one;

  assign tidx = tail_q[IDX_W-1:0];
  assign hidx = head_q[IDX_W-1:0];
  assign ridx = rsp_tag[IDX_W-1:0];

  assign iss_ready  = ((int'(occ_q) + int'(iss_pend)) < int'(QDEPTH)) && !vld_q[tidx];
  assign iss_fire   = iss_valid && iss_ready;
  assign iss_tag    = tail_q;
  assign rsp_hit    = rsp_valid && vld_q[ridx] && !done_q[ridx] && (tag_q[ridx] == rsp_tag);
  assign rsp_hit_store = st_q[ridx];
  assign head_ready = vld_q[hidx] && done_q[hidx];
  assign head_tag   = head_q;
  assign head_store = st_q[hidx];
  assign tbl_empty  = (occ_q == '0);
  assign free_one   = arrival_mode ? rsp_take : head_pop;

  always_comb begin
    tail_n = tail_q;
    head_n = head_q;
    vld_n  = vld_q;
    done_n = done_q;
    st_n   = st_q;
    tag_n  = tag_q;
    if (iss_fire) begin
      vld_n[tidx]  = 1'b1;
      done_n[tidx] = 1'b0;
      st_n[tidx]   = iss_store;
      tag_n[tidx]  = tail_q;
      tail_n       = tail_q + 1'b1;
    end
    if (rsp_take) begin
      if (arrival_mode) vld_n[ridx]  = 1'b0;
      else              done_n[ridx] = 1'b1;
    end
    if (head_pop) begin
      vld_n[hidx] = 1'b0;
      head_n      = head_q + 1'b1;
    end
    if (head_sync) head_n = tail_q;
    occ_n = occ_q + OCC_W'(iss_fire) - OCC_W'(free_one);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
      head_q <= '0;
      occ_q  <= '0;
      vld_q  <= '0;
      done_q <= '0;
      st_q   <= '0;
      for (int i = 0; i < int'(QDEPTH); i++) tag_q[i] <= '0;
    end else begin
      tail_q <= tail_n;
      head_q <= head_n;
      occ_q  <= occ_n;
      vld_q  <= vld_n;
      done_q <= done_n;
      st_q   <= st_n;
      tag_q  <= tag_n;
    end
  end

  // R2: tracked count never exceeds the queue size
  p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(QDEPTH));

  // R4: an unretired head response stays presented
  p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!arrival_mode && head_ready && !head_pop) |=> (head_ready && $stable(head_tag)));
endmodule

// File: rtl/mro_fifo.sv
module mro_fifo #(
  parameter int unsigned QDEPTH = 8,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned TS_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [TS_W-1:0]  push_ts,
  input  logic             pop,
  output logic             nonempty,
  output logic             wr_rdy,
  output logic [TAG_W-1:0] front_tag,
  output logic [TS_W-1:0]  front_ts
);
  localparam int unsigned IDX_W = $clog2(QDEPTH);
  localparam int unsigned PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] wp_q, rp_q, cnt;
  logic [TAG_W-1:0] tag_mem [QDEPTH];
  logic [TS_W-1:0]  ts_mem  [QDEPTH];

  assign cnt       = wp_q - rp_q;
  assign wr_rdy    = cnt < PTR_W'(QDEPTH);
  assign nonempty  = (cnt != '0);
  assign front_tag = tag_mem[rp_q[IDX_W-1:0]];
  assign front_ts  = ts_mem[rp_q[IDX_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      tag_mem[wp_q[IDX_W-1:0]] <= push_tag;
      ts_mem[wp_q[IDX_W-1:0]]  <= push_ts;
    end
  end

  // R6: no write into a full queue
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> wr_rdy);

  // R5: no pop from an empty queue
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);
endmodule

// File: rtl/mem_resp_order.sv
module mem_resp_order
  import mro_pkg::*;
#(
  parameter int unsigned QDEPTH = 8,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_req,
  output logic              mode_cur,
  input  logic              iss_valid,
  input  logic              iss_store,
  input  logic [PEND_W-1:0] iss_pend,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  output logic              ld_wr_rdy,
  output logic              st_wr_rdy,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_store,
  input  logic              out_done,
  output logic              err_flag
);
  // stamps of live queued entries span at most 2*QDEPTH arrivals
  localparam int unsigned TS_W = $clog2(QDEPTH) + 3;

  mro_mode_e        mode_q, mode_n;
  logic             err_q, err_n;
  logic [TS_W-1:0]  arr_q, arr_n;
  logic             arrival, iss_fire, all_empty, mode_chg;
  logic             rsp_hit, rsp_hit_store, rsp_take, q_room;
  logic             head_ready, head_store, head_pop, cmp_fire, pick_ld;
  logic [TAG_W-1:0] head_tag;
  logic             tbl_empty;
  logic [1:0]       f_push, f_pop, f_ne, f_rdy;
  logic [TAG_W-1:0] f_tag [2];
  logic [TS_W-1:0]  f_ts  [2];
  logic [TS_W-1:0]  ts_diff;

  assign arrival   = (mode_q == MODE_ARRIVAL);
  assign iss_fire  = iss_valid && iss_ready;
  assign all_empty = tbl_empty && (f_ne == 2'b00);
  assign mode_chg  = (mro_mode_e'(mode_req) != mode_q) && all_empty && !iss_fire;

  assign q_room   = rsp_hit_store ? f_rdy[1] : f_rdy[0];
  assign rsp_take = rsp_hit && (!arrival || q_room);
  assign f_push[0] = arrival && rsp_take && !rsp_hit_store;
  assign f_push[1] = arrival && rsp_take && rsp_hit_store;

  assign ts_diff  = f_ts[0] - f_ts[1];
  assign pick_ld  = f_ne[0] && (!f_ne[1] || ts_diff[TS_W-1]);

  assign out_valid = arrival ? (f_ne != 2'b00) : head_ready;
  assign out_tag   = arrival ? (pick_ld ? f_tag[0] : f_tag[1]) : head_tag;
  assign out_store = arrival ? !pick_ld : head_store;
  assign cmp_fire  = out_done && out_valid;
  assign head_pop  = cmp_fire && !arrival;
  assign f_pop[0]  = cmp_fire && arrival && pick_ld;
  assign f_pop[1]  = cmp_fire && arrival && !pick_ld;

  assign ld_wr_rdy = f_rdy[0];
  assign st_wr_rdy = f_rdy[1];
  assign mode_cur  = mode_q;
  assign err_flag  = err_q;

  mro_track #(.QDEPTH(QDEPTH), .TAG_W(TAG_W), .PEND_W(PEND_W)) u_track (
    .clk(clk), .rst_n(rst_n), .arrival_mode(arrival),
    .iss_valid(iss_valid), .iss_store(iss_store), .iss_pend(iss_pend),
    .iss_ready(iss_ready), .iss_tag(iss_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_hit(rsp_hit),
    .rsp_hit_store(rsp_hit_store), .rsp_take(rsp_take),
    .head_ready(head_ready), .head_tag(head_tag), .head_store(head_store),
    .head_pop(head_pop), .head_sync(mode_chg), .tbl_empty(tbl_empty)
  );

  // index 0 holds load responses, index 1 store responses
  for (genvar k = 0; k < 2; k++) begin : g_rspq
    mro_fifo #(.QDEPTH(QDEPTH), .TAG_W(TAG_W), .TS_W(TS_W)) u_q (
      .clk(clk), .rst_n(rst_n), .push(f_push[k]), .push_tag(rsp_tag),
      .push_ts(arr_q), .pop(f_pop[k]), .nonempty(f_ne[k]), .wr_rdy(f_rdy[k]),
      .front_tag(f_tag[k]), .front_ts(f_ts[k])
    );
  end

  always_comb begin
    mode_n = mode_q;
    err_n  = err_q;
    arr_n  = arr_q;
    if (mode_chg) mode_n = mro_mode_e'(mode_req);
    if (rsp_valid && !rsp_take) err_n = 1'b1;
    if (f_push != 2'b00) arr_n = arr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INORD;
      err_q  <= 1'b0;
      arr_q  <= '0;
    end else begin
      mode_q <= mode_n;
      err_q  <= err_n;
      arr_q  <= arr_n;
    end
  end

  // R7: error flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R8: policy holds while anything is tracked or queued
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !all_empty |=> $stable(mode_q));
endmodule

// File: tb/test_mem_resp_order.sv
`timescale 1ns/1ps
module test_mem_resp_order;
  localparam int Q = 8;
  localparam int TW = 4;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_req, iss_valid, iss_store, rsp_valid, out_done;
  logic [PW-1:0] iss_pend;
  logic [TW-1:0] rsp_tag;
  logic mode_cur, iss_ready, ld_wr_rdy, st_wr_rdy, out_valid, out_store, err_flag;
  logic [TW-1:0] iss_tag, out_tag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mem_resp_order #(.QDEPTH(Q), .TAG_W(TW), .PEND_W(PW)) i_mem_resp_order (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_cur(mode_cur),
    .iss_valid(iss_valid), .iss_store(iss_store), .iss_pend(iss_pend),
    .iss_ready(iss_ready), .iss_tag(iss_tag), .rsp_valid(rsp_valid),
    .rsp_tag(rsp_tag), .ld_wr_rdy(ld_wr_rdy), .st_wr_rdy(st_wr_rdy),
    .out_valid(out_valid), .out_tag(out_tag), .out_store(out_store),
    .out_done(out_done), .err_flag(err_flag)
  );

  // behavioural reference
  bit m_vld[Q];
  bit m_done[Q];
  bit m_st[Q];
  int m_tag[Q];
  int m_tail, m_head, m_occ, m_stamp;
  bit m_mode, m_err;
  int ldq[$];
  int ldts[$];
  int stq[$];
  int stts[$];

  function automatic bit m_iss_ready();
    return (m_occ + int'(iss_pend) < Q) && !m_vld[m_tail % Q];
  endfunction
  function automatic bit m_empty();
    return m_occ == 0 && ldq.size() == 0 && stq.size() == 0;
  endfunction
  function automatic bit m_pick_ld();
    if (ldq.size() == 0) return 0;
    if (stq.size() == 0) return 1;
    return ldts[0] < stts[0];
  endfunction
  function automatic bit m_out_valid();
    if (m_mode) return ldq.size() != 0 || stq.size() != 0;
    return m_vld[m_head % Q] && m_done[m_head % Q];
  endfunction
  function automatic int m_out_tag();
    if (m_mode) return m_pick_ld() ? ldq[0] : stq[0];
    return m_head;
  endfunction
  function automatic bit m_out_store();
    if (m_mode) return !m_pick_ld();
    return m_st[m_head % Q];
  endfunction

  task automatic m_reset();
    for (int i = 0; i < Q; i++) begin
      m_vld[i] = 0; m_done[i] = 0; m_st[i] = 0; m_tag[i] = 0;
    end
    m_tail = 0; m_head = 0; m_occ = 0; m_stamp = 0; m_mode = 0; m_err = 0;
    ldq.delete(); ldts.delete(); stq.delete(); stts.delete();
  endtask

  task automatic m_step();
    bit fire, hit, take, ov, pl, chg;
    int ridx;
    fire = iss_valid && m_iss_ready();
    ridx = int'(rsp_tag) % Q;
    hit  = rsp_valid && m_vld[ridx] && !m_done[ridx] && m_tag[ridx] == int'(rsp_tag);
    take = hit && (!m_mode || (m_st[ridx] ? stq.size() < Q : ldq.size() < Q));
    ov   = m_out_valid();
    pl   = m_pick_ld();
    chg  = (mode_req != m_mode) && m_empty() && !fire;
    if (rsp_valid && !take) m_err = 1;
    if (out_done && ov) begin
      if (!m_mode) begin
        m_vld[m_head % Q] = 0;
        m_head = (m_head + 1) % 16;
        m_occ--;
      end else if (pl) begin
        void'(ldq.pop_front()); void'(ldts.pop_front());
      end else begin
        void'(stq.pop_front()); void'(stts.pop_front());
      end
    end
    if (take) begin
      if (!m_mode) m_done[ridx] = 1;
      else begin
        m_vld[ridx] = 0;
        m_occ--;
        if (m_st[ridx]) begin stq.push_back(int'(rsp_tag)); stts.push_back(m_stamp); end
        else begin ldq.push_back(int'(rsp_tag)); ldts.push_back(m_stamp); end
        m_stamp++;
      end
    end
    if (fire) begin
      m_vld[m_tail % Q] = 1; m_done[m_tail % Q] = 0;
      m_st[m_tail % Q] = iss_store; m_tag[m_tail % Q] = m_tail;
      m_tail = (m_tail + 1) % 16;
      m_occ++;
    end
    if (chg) begin
      m_mode = mode_req;
      m_head = m_tail;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    int e;
    e = m_iss_ready();
    chk(iss_ready == e, "R2", "iss_ready", iss_ready, e);
    chk(int'(iss_tag) == m_tail, "R2", "iss_tag", iss_tag, m_tail);
    e = ldq.size() < Q;
    chk(ld_wr_rdy == e, "R6", "ld_wr_rdy", ld_wr_rdy, e);
    e = stq.size() < Q;
    chk(st_wr_rdy == e, "R6", "st_wr_rdy", st_wr_rdy, e);
    e = m_out_valid();
    chk(out_valid == e, m_mode ? "R5" : "R3", "out_valid", out_valid, e);
    if (e && out_valid) begin
      chk(int'(out_tag) == m_out_tag(), m_mode ? "R5" : "R4", "out_tag", out_tag, m_out_tag());
      chk(out_store == m_out_store(), m_mode ? "R5" : "R3", "out_store", out_store, m_out_store());
    end
    chk(err_flag == m_err, "R7", "err_flag", err_flag, m_err);
    chk(mode_cur == m_mode, "R8", "mode_cur", mode_cur, m_mode);
  endtask

  task automatic cycle();
    @(posedge clk);
    m_step();
    cyc++;
    @(negedge clk);
    compare();
  endtask

  // pick an outstanding unfinished tag that can be taken
  task automatic pick_rsp(output bit found, output int tag);
    int cand[$];
    for (int s = 0; s < Q; s++)
      if (m_vld[s] && !m_done[s] &&
          (!m_mode || (m_st[s] ? stq.size() < Q : ldq.size() < Q)))
        cand.push_back(m_tag[s]);
    found = cand.size() != 0;
    tag = found ? cand[$urandom_range(cand.size() - 1)] : 0;
  endtask

  task automatic drive(input bit mreq, input int iss_pct, input int cmp_pct, input int rsp_pct, input bit only_loads);
    bit f;
    int t;
    mode_req  = mreq;
    iss_valid = ($urandom_range(99) < iss_pct);
    iss_store = only_loads ? 1'b0 : 1'($urandom_range(1));
    iss_pend  = PW'($urandom_range(3));
    pick_rsp(f, t);
    rsp_valid = f && ($urandom_range(99) < rsp_pct);
    rsp_tag   = TW'(t);
    out_done  = ($urandom_range(99) < cmp_pct);
  endtask

  task automatic run(input int n, input bit mreq, input int iss_pct, input int cmp_pct, input int rsp_pct, input bit only_loads);
    for (int i = 0; i < n; i++) begin
      drive(mreq, iss_pct, cmp_pct, rsp_pct, only_loads);
      cycle();
    end
  endtask

  task automatic drain(input bit mreq);
    for (int i = 0; i < 300 && !(m_empty() && m_mode == mreq); i++) begin
      drive(mreq, 0, 100, 100, 0);
      cycle();
    end
  endtask

  initial begin
    rst_n = 0; mode_req = 0; iss_valid = 0; iss_store = 0; iss_pend = '0;
    rsp_valid = 0; rsp_tag = '0; out_done = 0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(iss_ready == 1, "R1", "iss_ready", iss_ready, 1);
    chk(ld_wr_rdy == 1 && st_wr_rdy == 1, "R1", "wr_rdy", {ld_wr_rdy, st_wr_rdy}, 3);
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(err_flag == 0, "R1", "err_flag", err_flag, 0);
    chk(mode_cur == 0, "R1", "mode_cur", mode_cur, 0);
    chk(iss_tag == '0, "R1", "iss_tag", iss_tag, 0);
    // R3 R4: program order, varied traffic
    run(400, 0, 60, 50, 60, 0);
    run(200, 0, 90, 10, 30, 0);
    // R8: arrival order asked while busy
    run(150, 1, 80, 30, 40, 0);
    drain(1);
    // R5: arrival order, mixed types
    run(400, 1, 60, 50, 60, 0);
    // R6: completions held back so the load queue fills
    run(80, 1, 90, 0, 90, 1);
    run(40, 1, 50, 60, 60, 0);
    drain(0);
    run(200, 0, 60, 50, 60, 0);
    drain(0);
    // R7: unmatched tag on an idle block
    mode_req = 0; iss_valid = 0; out_done = 0; rsp_valid = 1; rsp_tag = TW'(5);
    cycle();
    rsp_valid = 0;
    cycle();
    chk(err_flag == 1, "R7", "err after stray tag", err_flag, 1);
    chk(out_valid == 0, "R7", "stray tag had no effect", out_valid, 0);
    run(100, 0, 60, 50, 60, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule